// File: doc/BRIEF.md
# Eight-Channel Single-Move Event Transfer Engine

This block services granted interrupt requests by moving one data unit without involving the processor's software. An arbiter hands it a channel number. The engine then reads one byte or one 16-bit word from that channel's source pointer and writes it to that channel's destination pointer. Both pointers are 16-bit addresses in one 64 KB space. Neither a block move nor any save of processor state takes place. While the move is in progress the processor stall line is held high. Afterwards the selected pointer can step forward and the channel's transfer count is updated.

Each of the eight channels is programmed through a small synchronous register port. Each channel has a control word, a source pointer and a destination pointer. Triggers that arrive while the engine is busy are held as one pending flag per channel. Pending channels are then served from the lowest index upward. A channel whose count is used up no longer moves data. Instead it raises an ordinary interrupt request, so that software can take over.

Top module: `evt_mover`

## Requirements
- R1: After reset the engine is idle: `cpu_stall`, `mem_req`, `done` and `irq_req` are low, and every channel register reads back as zero.
- R2: The register address is `{channel[2:0], sel[1:0]}`. Select 0 is control, with bit 0 = word mode, bits 2:1 = step select and bits 15:8 = count. Select 1 is the source pointer, select 2 is the destination pointer and select 3 reads zero. A write takes effect at the clock edge, and reads are combinational.
- R3: The clock edge that samples `trig_valid` sets the channel's pending flag. The next edge starts the move. The engine then spends one read cycle (`mem_req`=1, `mem_we`=0, source address) followed by one write cycle (`mem_we`=1, destination address), and `cpu_stall` is high in exactly these two cycles. `done` is high for the following cycle only, with `done_ch` giving the channel.
- R4: In byte mode the byte is taken from lane `src[0]` of the read word (0 = bits 7:0, 1 = bits 15:8). It is written to lane `dst[0]` with `mem_be` = 01 or 10, so the other byte of the destination word is left unchanged.
- R5: In word mode address bit 0 is ignored on both sides. The full word is moved with `mem_be` = 11 at even addresses.
- R6: Step select 01 advances the source pointer and 10 advances the destination pointer. Select 00 or 11 leaves both unchanged. The step is 1 in byte mode and 2 in word mode.
- R7: After each move the count decreases by one, except that a count of 0xFF stays 0xFF.
- R8: A trigger on a channel whose count is 0 performs no memory access and no stall. Instead `irq_req` is high for one cycle, with `irq_ch` giving the channel, in the cycle where a move would have started.
- R9: A move that brings the count from 1 to 0 raises `irq_req` with `irq_ch` in the same cycle as `done`.
- R10: Each channel holds at most one pending request, and further triggers on an already pending channel are dropped. When idle, the engine serves the lowest-numbered pending channel first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address {channel, select} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| trig_valid | input | 1 | Granted request from the arbiter |
| trig_ch | input | 3 | Channel of the granted request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_be | output | 2 | Byte enables for a write |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| cpu_stall | output | 1 | Processor hold during a move |
| done | output | 1 | One-cycle move completion pulse |
| done_ch | output | 3 | Channel of the completed move |
| irq_req | output | 1 | One-cycle normal interrupt request |
| irq_ch | output | 3 | Channel of the interrupt request |

## Verification
A trigger driven before clock edge E0 is pending after E0. The read cycle with stall follows E1, the write cycle follows E2, and `done` plus any count-exhaustion interrupt follow E3. For a channel with a zero count, the interrupt follows E1 instead. The bench drives every input on the falling edge and checks each of these outputs at the falling edge after exactly the edge where it is due, and never by polling. Pointer and count updates are read back through the register port once `done` has been seen. The queuing test reads the order of `done_ch` values over a fixed window.

// File: rtl/evt_mover.sv
module evt_mover #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CHW = $clog2(NCH),
  localparam int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW+1:0] cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  input  logic           trig_valid,
  input  logic [CHW-1:0] trig_ch,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_be,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           cpu_stall,
  output logic           done,
  output logic [CHW-1:0] done_ch,
  output logic           irq_req,
  output logic [CHW-1:0] irq_ch
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t            st_q;
  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [1:0]     inc_q [NCH];
  logic [NCH-1:0] word_q;
  logic [NCH-1:0] pend_q;
  logic [CHW-1:0] cur_q;
  logic [CHW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) pick = CHW'(i);
  end

  wire             any_pend  = |pend_q;
  wire [CHW-1:0]   cfg_ch    = cfg_addr[CHW+1:2];
  wire [1:0]       cfg_sel   = cfg_addr[1:0];
  wire [AW-1:0]    cur_src   = src_q[cur_q];
  wire [AW-1:0]    cur_dst   = dst_q[cur_q];
  wire             cur_word  = word_q[cur_q];
  wire [CW-1:0]    cur_cnt   = cnt_q[cur_q];
  wire [AW-1:0]    step      = cur_word ? AW'(2) : AW'(1);
  wire             fin       = (st_q == S_WR);
  wire [CW-1:0]    cnt_nxt   = (cur_cnt == '1) ? cur_cnt : cur_cnt - 1'b1;
  wire [7:0]       rd_byte   = cur_src[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  wire [NCH-1:0]   trig_vec  = trig_valid ? (NCH'(1) << trig_ch) : '0;
  wire [NCH-1:0]   clr_vec   = (st_q == S_IDLE && any_pend) ? (NCH'(1) << pick) : '0;
  wire [AW-1:0]    ptr       = fin ? cur_dst : cur_src;

  assign cpu_stall = (st_q != S_IDLE);
  assign mem_req   = cpu_stall;
  assign mem_we    = fin;
  assign mem_addr  = {ptr[AW-1:1], cur_word ? 1'b0 : ptr[0]};
  assign mem_be    = cur_word ? 2'b11 : (ptr[0] ? 2'b10 : 2'b01);
  assign mem_wdata = cur_word ? mem_rdata : {rd_byte, rd_byte};

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      2'd0: begin
        cfg_rdata[0]           = word_q[cfg_ch];
        cfg_rdata[2:1]         = inc_q[cfg_ch];
        cfg_rdata[AW-1 -: CW]  = cnt_q[cfg_ch];
      end
      2'd1:    cfg_rdata = src_q[cfg_ch];
      2'd2:    cfg_rdata = dst_q[cfg_ch];
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      pend_q  <= '0;
      done    <= 1'b0;
      done_ch <= '0;
      irq_req <= 1'b0;
      irq_ch  <= '0;
    end else begin
      done    <= 1'b0;
      irq_req <= 1'b0;
      pend_q  <= (pend_q & ~clr_vec) | trig_vec;
      case (st_q)
        S_IDLE: if (any_pend) begin
          cur_q <= pick;
          if (cnt_q[pick] == '0) begin
            irq_req <= 1'b1;
            irq_ch  <= pick;
          end else begin
            st_q <= S_RD;
          end
        end
        S_RD: st_q <= S_WR;
        default: begin
          st_q    <= S_IDLE;
          done    <= 1'b1;
          done_ch <= cur_q;
          if (cnt_nxt == '0) begin
            irq_req <= 1'b1;
            irq_ch  <= cur_q;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        inc_q[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            word_q[cfg_ch] <= cfg_wdata[0];
            inc_q[cfg_ch]  <= cfg_wdata[2:1];
            cnt_q[cfg_ch]  <= cfg_wdata[AW-1 -: CW];
          end
          2'd1:    src_q[cfg_ch] <= cfg_wdata;
          2'd2:    dst_q[cfg_ch] <= cfg_wdata;
          default: ;
        endcase
      end
      if (fin) begin
        cnt_q[cur_q] <= cnt_nxt;
        if (inc_q[cur_q] == 2'b01) src_q[cur_q] <= cur_src + step;
        if (inc_q[cur_q] == 2'b10) dst_q[cur_q] <= cur_dst + step;
      end
    end
  end

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));

  a_r3_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (done && !cpu_stall));

  a_r5_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 2'b11) |-> !mem_addr[0]);

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be != 2'b11) |-> $onehot(mem_be));

  a_r7_inf_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cur_cnt == '1 && !cfg_we) |=> (cnt_q[$past(cur_q)] == '1));

  a_r8_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !done) |-> !cpu_stall);

  a_r10_trigger_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !(st_q == S_IDLE && any_pend)) |=> pend_q[$past(trig_ch)]);

endmodule

// File: tb/tb_evt_mover.sv
module tb_evt_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        trig_valid = 1'b0;
  logic [2:0]  trig_ch = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata = '0;
  logic        cpu_stall, done, irq_req;
  logic [2:0]  done_ch, irq_ch;

  always #5 clk = ~clk;

  evt_mover dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trig_valid(trig_valid), .trig_ch(trig_ch),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cpu_stall(cpu_stall), .done(done), .done_ch(done_ch),
    .irq_req(irq_req), .irq_ch(irq_ch)
  );

  logic [15:0] mem [256];
  int wr_cnt = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:1]];
    if (mem_req && mem_we) begin
      wr_cnt <= wr_cnt + 1;
      if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
    end
  end

  typedef struct packed {
    logic [2:0]  ch;
    logic        word;
    logic [1:0]  inc;
    logic [7:0]  cnt;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] sword;
    logic [15:0] exp_dw;
    logic [15:0] exp_src;
    logic [15:0] exp_dst;
    logic [7:0]  exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 1'b1, 2'b01, 8'h03, 16'h0010, 16'h0020, 16'hA55A, 16'hA55A, 16'h0012, 16'h0020, 8'h02, 1'b0},
    '{3'd3, 1'b0, 2'b10, 8'h05, 16'h0031, 16'h0040, 16'h12C3, 16'hEE12, 16'h0031, 16'h0041, 8'h04, 1'b0},
    '{3'd7, 1'b0, 2'b00, 8'hFF, 16'h0050, 16'h0063, 16'hBE7F, 16'h7FEE, 16'h0050, 16'h0063, 8'hFF, 1'b0},
    '{3'd5, 1'b1, 2'b11, 8'h02, 16'h0071, 16'h0083, 16'h4D21, 16'h4D21, 16'h0071, 16'h0083, 8'h01, 1'b0},
    '{3'd1, 1'b0, 2'b01, 8'h01, 16'h0090, 16'h00A1, 16'h33CC, 16'hCCEE, 16'h0091, 16'h00A1, 8'h00, 1'b1},
    '{3'd2, 1'b1, 2'b10, 8'h10, 16'h00B0, 16'h00C0, 16'h0F0F, 16'h0F0F, 16'h00B0, 16'h00C2, 8'h0F, 1'b0}
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] ch, input logic [1:0] sel, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = {ch, sel}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] ch, input logic [1:0] sel, output logic [15:0] d);
    cfg_addr = {ch, sel};
    #1 d = cfg_rdata;
  endtask

  task automatic trig(input logic [2:0] ch);
    trig_valid = 1'b1; trig_ch = ch;
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    logic [2:0]  seen [8];
    int          nseen;
    int          wr0;

    repeat (3) @(negedge clk);
    chk("R1", "stall", cpu_stall, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "done", done, 0);
    chk("R1", "irq", irq_req, 0);
    rd_reg(3'd0, 2'd0, rv); chk("R1", "ctrl0", rv, 0);
    rd_reg(3'd7, 2'd1, rv); chk("R1", "src7", rv, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 256; k++) mem[k] = 16'hEEEE;
      mem[VEC[v].src[8:1]] = VEC[v].sword;
      wr_reg(VEC[v].ch, 2'd0, {VEC[v].cnt, 5'b0, VEC[v].inc, VEC[v].word});
      wr_reg(VEC[v].ch, 2'd1, VEC[v].src);
      wr_reg(VEC[v].ch, 2'd2, VEC[v].dst);
      rd_reg(VEC[v].ch, 2'd0, rv);
      chk("R2", "ctrl readback", rv, {VEC[v].cnt, 5'b0, VEC[v].inc, VEC[v].word});
      trig(VEC[v].ch);
      chk("R3", "no stall before start", cpu_stall, 0);
      @(negedge clk);
      chk("R3", "read cycle stall", cpu_stall, 1);
      chk("R3", "read cycle req/we", {mem_req, mem_we}, 2'b10);
      chk("R5", "read addr", mem_addr, VEC[v].word ? {VEC[v].src[15:1], 1'b0} : VEC[v].src);
      @(negedge clk);
      chk("R3", "write cycle req/we", {mem_req, mem_we, cpu_stall}, 3'b111);
      chk("R5", "write addr", mem_addr, VEC[v].word ? {VEC[v].dst[15:1], 1'b0} : VEC[v].dst);
      chk("R4", "write be", mem_be, VEC[v].word ? 2'b11 : (VEC[v].dst[0] ? 2'b10 : 2'b01));
      @(negedge clk);
      chk("R3", "done pulse", {done, cpu_stall}, 2'b10);
      chk("R3", "done_ch", done_ch, VEC[v].ch);
      chk("R9", "irq at done", irq_req, VEC[v].exp_irq);
      if (VEC[v].exp_irq) chk("R9", "irq_ch", irq_ch, VEC[v].ch);
      chk(VEC[v].word ? "R5" : "R4", "dest word", mem[VEC[v].dst[8:1]], VEC[v].exp_dw);
      rd_reg(VEC[v].ch, 2'd1, rv); chk("R6", "src after", rv, VEC[v].exp_src);
      rd_reg(VEC[v].ch, 2'd2, rv); chk("R6", "dst after", rv, VEC[v].exp_dst);
      rd_reg(VEC[v].ch, 2'd0, rv); chk("R7", "count after", rv[15:8], VEC[v].exp_cnt);
      @(negedge clk);
      chk("R3", "done one cycle", done, 0);
    end

    rd_reg(3'd7, 2'd3, rv); chk("R2", "select 3 reads zero", rv, 0);

    // R8: zero count gives interrupt, no move
    wr_reg(3'd4, 2'd0, 16'h0000);
    wr0 = wr_cnt;
    trig(3'd4);
    @(negedge clk);
    chk("R8", "irq", irq_req, 1);
    chk("R8", "irq_ch", irq_ch, 3'd4);
    chk("R8", "no stall", {cpu_stall, mem_req}, 2'b00);
    @(negedge clk);
    chk("R8", "irq one cycle", irq_req, 0);
    repeat (4) @(negedge clk);
    chk("R8", "no memory write", wr_cnt, wr0);

    // R10: queuing and lowest-first service
    wr_reg(3'd6, 2'd0, 16'hFF01);
    wr_reg(3'd6, 2'd1, 16'h0010);
    wr_reg(3'd6, 2'd2, 16'h0020);
    wr_reg(3'd0, 2'd0, 16'hFF01);
    nseen = 0;
    fork
      begin
        trig(3'd6);
        @(negedge clk);
        trig(3'd6);
        trig(3'd0);
        trig(3'd6);
      end
      begin
        for (int c = 0; c < 30; c++) begin
          @(negedge clk);
          if (done && nseen < 8) begin
            seen[nseen] = done_ch;
            nseen++;
          end
        end
      end
    join
    chk("R10", "service count", nseen, 3);
    chk("R10", "first", seen[0], 3'd6);
    chk("R10", "second lowest", seen[1], 3'd0);
    chk("R10", "third", seen[2], 3'd6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule